// File: doc/BRIEF.md
# Commit-Stall Watchdog for an Out-of-Order Retire Queue

This block watches the oldest slot of an out-of-order instruction queue, the slot that retires next. It counts consecutive clock cycles in which that slot holds a live instruction and the head pointer does not move. When the count reaches a programmable limit, the watchdog does not reset anything. It raises a one-cycle force-commit strobe, which the queue uses to retire the stuck instruction. In the same cycle it raises an exception marked with a dedicated cause code and reports the slot number. The handler returns to the faulting instruction, so that instruction runs again. A broken commit path then makes the machine slow rather than hung.

The limit is chosen above the slowest instruction (about 150 cycles) plus a cache line fill. The default of 300 cycles meets that. The cause code also records whether the stuck head had finished executing, which tells a commit-logic fault apart from an execution that never completed.

Top module: `commit_stall_watchdog`

## Requirements
- R1: While reset is asserted and in the first cycle after it, force_commit_o and exc_o are low, exc_cause_o is 0 and exc_idx_o is 0.
- R2: A stall cycle is a cycle in which the head slot is valid, head_adv_i is low and flush_i is low. After exactly LIMIT consecutive stall cycles, force_commit_o is high in the cycle that follows the LIMIT-th stall cycle, and never earlier.
- R3: A head advance clears the stall count, so LIMIT-1 stall cycles followed by an advance produce no strobe, and a new full run of LIMIT stall cycles is then needed.
- R4: force_commit_o is high for exactly one cycle per timeout. No further strobe occurs, however long the stall lasts, until the head advances or a flush occurs.
- R5: A head advance after a timeout re-arms the watchdog, so the next run of LIMIT stall cycles fires again.
- R6: flush_i clears the count and re-arms the watchdog. A flush in the cycle that would have been the LIMIT-th stall cycle suppresses the strobe.
- R7: exc_o is high in exactly the cycles where force_commit_o is high. While exc_o is high, exc_idx_o equals the head index that was present during the LIMIT-th stall cycle. exc_idx_o is 0 otherwise.
- R8: The 4-bit exc_cause_o is 4'h8 when the head slot was not done during the LIMIT-th stall cycle, and 4'h9 when it was done. It is 4'h0 whenever exc_o is low.
- R9: A cycle in which the head slot is not valid is not a stall cycle and clears the count. An empty queue therefore never times out.
- R10: Only the valid and done bits of the slot selected by head_idx_i affect the watchdog. Bits of every other slot have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Pipeline flush: clears count and re-arms |
| head_idx_i | input | IDX_W | Index of the oldest queue slot |
| head_adv_i | input | 1 | Pulse: head pointer moves this cycle |
| entry_valid_i | input | DEPTH | Per-slot occupied flag |
| entry_done_i | input | DEPTH | Per-slot execution-finished flag |
| force_commit_o | output | 1 | One-cycle strobe: retire the head now |
| exc_o | output | 1 | Exception raised on the timed-out head |
| exc_cause_o | output | 4 | Exception cause code |
| exc_idx_o | output | IDX_W | Slot index of the faulting instruction |

## Verification
A count that runs one step fast or slow shows up as a strobe one cycle off the expected edge. The bench watches every cycle, so the error appears on the very first timeout. A missing re-arm shows as a silent second stall, visible LIMIT cycles after the advance. A failure to disarm shows as a second strobe within LIMIT cycles of the first. A wrong head-slot selection shows as a wrong cause code or index at the moment of timeout, or as a strobe while the head is empty.

// File: rtl/cmt_wdog_pkg.sv
package cmt_wdog_pkg;
    localparam int CAUSE_W = 4;
    typedef logic [CAUSE_W-1:0] cause_t;
    localparam cause_t CAUSE_NONE     = 4'h0;
    localparam cause_t CAUSE_TMO_PEND = 4'h8;
    localparam cause_t CAUSE_TMO_DONE = 4'h9;
endpackage

// File: rtl/cmt_head_select.sv
module cmt_head_select #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] head_idx_i,
    input  logic [DEPTH-1:0] valid_i,
    input  logic [DEPTH-1:0] done_i,
    output logic             head_valid_o,
    output logic             head_done_o
);
    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        assign hit[g] = (head_idx_i == IDX_W'(g));
    end

    always_comb begin
        head_valid_o = |(hit & valid_i);
        head_done_o  = |(hit & done_i);
    end
endmodule

// File: rtl/cmt_stall_timer.sv
module cmt_stall_timer #(
    parameter int LIMIT = 300,
    parameter int CNT_W = $clog2(LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic adv_i,
    input  logic head_live_i,
    output logic timeout_now_o,
    output logic fire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             fire;
    } tmr_t;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    tmr_t st_d, st_q;
    logic stall;

    always_comb begin
        stall         = head_live_i && !adv_i && !flush_i;
        timeout_now_o = st_q.armed && stall && (st_q.cnt == LAST);
        st_d          = st_q;
        st_d.fire     = 1'b0;
        if (flush_i || adv_i) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end else if (!st_q.armed || !head_live_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
            st_d.fire  = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.armed <= 1'b1;
            st_q.fire  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_o = st_q.fire;

    initial assert (LIMIT >= 2);

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    assert_fire_needs_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(stall));
    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
    assert_flush_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !fire_o);
    assert_empty_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !head_live_i |=> !fire_o);
endmodule

// File: rtl/cmt_fault_report.sv
module cmt_fault_report
    import cmt_wdog_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             timeout_now_i,
    input  logic             head_done_i,
    input  logic [IDX_W-1:0] head_idx_i,
    output logic             exc_o,
    output cause_t           cause_o,
    output logic [IDX_W-1:0] idx_o
);
    typedef struct packed {
        logic             exc;
        cause_t           cause;
        logic [IDX_W-1:0] idx;
    } rpt_t;

    rpt_t rp_d, rp_q;

    always_comb begin
        rp_d.exc   = 1'b0;
        rp_d.cause = CAUSE_NONE;
        rp_d.idx   = '0;
        if (timeout_now_i) begin
            rp_d.exc   = 1'b1;
            rp_d.cause = head_done_i ? CAUSE_TMO_DONE : CAUSE_TMO_PEND;
            rp_d.idx   = head_idx_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rp_q <= '0;
        else        rp_q <= rp_d;
    end

    assign exc_o   = rp_q.exc;
    assign cause_o = rp_q.cause;
    assign idx_o   = rp_q.idx;

    assert_cause_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> (cause_o == CAUSE_TMO_PEND || cause_o == CAUSE_TMO_DONE));
    assert_cause_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_o |-> (cause_o == CAUSE_NONE && idx_o == '0));
endmodule

// File: rtl/commit_stall_watchdog.sv
module commit_stall_watchdog
    import cmt_wdog_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LIMIT = 300,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic [IDX_W-1:0]   head_idx_i,
    input  logic               head_adv_i,
    input  logic [DEPTH-1:0]   entry_valid_i,
    input  logic [DEPTH-1:0]   entry_done_i,
    output logic               force_commit_o,
    output logic               exc_o,
    output logic [CAUSE_W-1:0] exc_cause_o,
    output logic [IDX_W-1:0]   exc_idx_o
);
    logic head_valid, head_done, timeout_now;

    cmt_head_select #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_sel (
        .head_idx_i   (head_idx_i),
        .valid_i      (entry_valid_i),
        .done_i       (entry_done_i),
        .head_valid_o (head_valid),
        .head_done_o  (head_done)
    );

    cmt_stall_timer #(.LIMIT(LIMIT)) u_tmr (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (flush_i),
        .adv_i         (head_adv_i),
        .head_live_i   (head_valid),
        .timeout_now_o (timeout_now),
        .fire_o        (force_commit_o)
    );

    cmt_fault_report #(.IDX_W(IDX_W)) u_rpt (
        .clk           (clk),
        .rst_n         (rst_n),
        .timeout_now_i (timeout_now),
        .head_done_i   (head_done),
        .head_idx_i    (head_idx_i),
        .exc_o         (exc_o),
        .cause_o       (exc_cause_o),
        .idx_o         (exc_idx_o)
    );

    assert_exc_tracks_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o == force_commit_o);
endmodule

// File: tb/sim_commit_stall_watchdog.sv
`timescale 1ns/1ps
module sim_commit_stall_watchdog;
    localparam int DEPTH = 4;
    localparam int LIMIT = 12;
    localparam int IW    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0, adv = 1'b0;
    logic [IW-1:0] hidx = '0;
    logic [DEPTH-1:0] vld = '0, dn = '0;
    logic fc, ex;
    logic [3:0] cause;
    logic [IW-1:0] eidx;

    int checks = 0, errors = 0;
    bit finished = 0;

    // bench-side expectation state
    int  m_cnt = 0;
    bit  m_armed = 1;
    bit  e_fire = 0;
    logic [3:0] e_cause = 0;
    logic [IW-1:0] e_idx = 0;

    always #2.5 clk = ~clk;

    commit_stall_watchdog #(.DEPTH(DEPTH), .LIMIT(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .head_idx_i(hidx),
        .head_adv_i(adv), .entry_valid_i(vld), .entry_done_i(dn),
        .force_commit_o(fc), .exc_o(ex), .exc_cause_o(cause), .exc_idx_o(eidx)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: apply inputs, model what the requirements say, compare after the edge
    task automatic cyc(input logic [IW-1:0] i, input logic [DEPTH-1:0] v,
                       input logic [DEPTH-1:0] d, input bit a, input bit f, input string req);
        bit live, stall;
        hidx = i; vld = v; dn = d; adv = a; flush = f;
        @(negedge clk);
        live  = v[i];
        stall = live && !a && !f;
        e_fire = 0; e_cause = 4'h0; e_idx = '0;
        if (a || f) begin
            m_cnt = 0; m_armed = 1;
        end else if (!m_armed || !stall) begin
            m_cnt = 0;
        end else begin
            m_cnt++;
            if (m_cnt == LIMIT) begin
                e_fire = 1; m_armed = 0; m_cnt = 0;
                e_cause = d[i] ? 4'h9 : 4'h8;
                e_idx = i;
            end
        end
        check(fc == e_fire, req, fc, e_fire);
        check(ex == e_fire, "R7", ex, e_fire);
        check(cause == e_cause, "R8", cause, e_cause);
        check(eidx == e_idx, "R7", eidx, e_idx);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check(fc == 0 && ex == 0, "R1", fc, 0);
        check(cause == 0 && eidx == 0, "R1", cause, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(fc == 0 && ex == 0 && cause == 0 && eidx == 0, "R1", fc, 0);

        // R2, R4, R7, R8, R10: every head slot, both done values, other slots scrambled
        for (int i = 0; i < DEPTH; i++) begin
            for (int d = 0; d < 2; d++) begin
                logic [DEPTH-1:0] dv;
                dv = {DEPTH{d[0] ? 1'b0 : 1'b1}};
                dv[i] = d[0];
                cyc(IW'(i), '1, dv, 0, 1, "R6");
                for (int k = 0; k < LIMIT + 5; k++)
                    cyc(IW'(i), (k % 2 == 0) ? '1 : 4'(1 << i), dv, 0, 0, "R2");
                cyc(IW'(i), '1, dv, 1, 0, "R5");
            end
        end

        // R3: near miss then advance, then full run needed again
        for (int k = 0; k < LIMIT - 1; k++) cyc(1, '1, '0, 0, 0, "R3");
        cyc(1, '1, '0, 1, 0, "R3");
        for (int k = 0; k < LIMIT + 1; k++) cyc(2, '1, '0, 0, 0, "R3");

        // R4: long stall after timeout stays silent
        for (int k = 0; k < 3 * LIMIT; k++) cyc(2, '1, '1, 0, 0, "R4");

        // R5: advance re-arms
        cyc(2, '1, '1, 1, 0, "R5");
        for (int k = 0; k < LIMIT + 2; k++) cyc(3, '1, '1, 0, 0, "R5");

        // R6: flush in the would-be last stall cycle, and flush mid-run
        cyc(3, '1, '0, 1, 0, "R6");
        for (int k = 0; k < LIMIT - 1; k++) cyc(0, '1, '0, 0, 0, "R6");
        cyc(0, '1, '0, 0, 1, "R6");
        for (int k = 0; k < LIMIT / 2; k++) cyc(0, '1, '0, 0, 0, "R6");
        cyc(0, '1, '0, 0, 1, "R6");
        for (int k = 0; k < LIMIT + 1; k++) cyc(0, '1, '0, 0, 0, "R6");
        cyc(0, '1, '0, 1, 0, "R5");

        // R9: empty head breaks the run; empty queue never fires
        for (int k = 0; k < LIMIT - 1; k++) cyc(1, '1, '0, 0, 0, "R9");
        cyc(1, 4'b1101, '0, 0, 0, "R9");
        for (int k = 0; k < LIMIT + 1; k++) cyc(1, '1, '0, 0, 0, "R9");
        cyc(1, '1, '0, 1, 0, "R5");
        for (int k = 0; k < 2 * LIMIT; k++) cyc(3, 4'b0111, '1, 0, 0, "R9");

        // R10: toggling other slots' done bits does not change cause
        cyc(3, '1, '0, 1, 0, "R10");
        for (int k = 0; k < LIMIT + 1; k++)
            cyc(3, '1, (k % 2 == 0) ? 4'b0111 : 4'b0000, 0, 0, "R10");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule